// File: doc/BRIEF.md
# Multiprocessor-Aware Serial Receiver

This block turns a serial input line into data bytes for one of four framing modes. Mode 0 is a synchronous shift mode: the block drives its own shift clock and takes in eight bits. Mode 1 is an asynchronous frame of start bit, eight data bits and stop bit. Modes 2 and 3 add a ninth data bit before the stop bit. Each finished frame can load a receive buffer, store an extra bit and raise a receive-done flag. A sticky framing-error flag records any frame whose stop bit sampled low.

Receive-done raising can be filtered for multiprocessor networks. With the filter enabled, nine-bit frames are accepted only when the ninth bit is 1, which marks an address frame. Eight-bit frames are accepted only when their stop bit is valid. One status bit position is shared: a view select chooses whether it shows the upper mode bit or the framing-error flag.

The bit rate is generated outside the block. It receives a tick at sixteen times the bit rate for modes 1 to 3. Modes 2 and 3 behave the same inside the block and differ only in where that tick comes from. It also receives a tick at twice the shift rate for mode 0. Software actions reach the block as one-cycle clear pulses.

Top module: `mpc_serial_rx`

## Requirements
- R1: After reset the block shows the following state. The receive-done flag is 0, the framing-error flag is 0, the buffer is 0, the extra bit is 0 and the shift clock output idles high.
- R2: In mode 1 (`mode_i` = 2'b01), a frame is received as follows. A low start bit is followed by eight data bits, least significant first, then a stop bit. The data loads the buffer, the sampled stop bit is stored as the extra bit, and receive-done is set.
- R3: In modes 2 and 3 (`mode_i` = 2'b10 or 2'b11), the ninth bit received after the data is stored as the extra bit. The stop bit does not affect the extra bit or whether the frame is accepted.
- R4: With the address filter on in mode 2 or 3, a frame whose ninth bit is 0 leaves receive-done, the buffer and the extra bit unchanged. A frame whose ninth bit is 1 is accepted.
- R5: With the address filter on in mode 1, a frame whose stop bit samples 0 is not accepted.
- R6: A stop bit that samples 0 in modes 1 to 3 sets the framing-error flag. The flag stays set through later valid frames until a clear pulse on `clr_fe_i`.
- R7: `ctrl7_o` shows the framing-error flag while `fe_view_i` is 1. It shows `mode_i[1]` while `fe_view_i` is 0.
- R8: While the receive enable is 0, no frame is received, receive-done does not rise and the shift clock stays high.
- R9: A start bit is taken only from a falling edge of the line. If a majority of the samples at the bit centre read high, the start is dropped.
- R10: Every bit is decided by a majority of three samples taken on consecutive rate ticks around the bit centre. A glitch that covers one sample does not change the bit.
- R11: A frame that ends while receive-done is still set is discarded. The buffer and extra bit keep their values and receive-done stays 1.
- R12: In mode 0 (`mode_i` = 2'b00), reception starts when the enable is 1 and receive-done is 0. The block toggles `sclk_o` on each shift tick and samples the line on each rising edge. It collects 8 bits least significant first, loads the buffer, sets receive-done and leaves the extra bit unchanged. While receive-done is 1 the shift clock stays high.
- R13: A pulse on `clr_ri_i` clears receive-done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial data line (asynchronous) |
| rx_en_i | input | 1 | Receive enable |
| addr_filt_i | input | 1 | Multiprocessor address filter enable |
| mode_i | input | 2 | Framing mode: 00 shift, 01 8-bit, 10/11 9-bit |
| fe_view_i | input | 1 | Selects framing-error view of the shared bit |
| ovs_tick_i | input | 1 | Tick at 16 times the bit rate (modes 1 to 3) |
| sh_tick_i | input | 1 | Tick at twice the shift rate (mode 0) |
| clr_ri_i | input | 1 | Clear pulse for receive-done |
| clr_fe_i | input | 1 | Clear pulse for framing error |
| rx_data_o | output | 8 | Receive buffer |
| rb8_o | output | 1 | Extra bit (stop bit or ninth bit) |
| ri_o | output | 1 | Receive-done flag |
| fe_o | output | 1 | Sticky framing-error flag |
| ctrl7_o | output | 1 | Shared bit: framing error or upper mode bit |
| sclk_o | output | 1 | Mode 0 shift clock output |

## Verification
Frames are sent in all four modes with different byte values and with the ninth bit and stop bit at both levels. The filter is exercised both on and off. This separates acceptance driven by the ninth bit from acceptance driven by the stop bit, and shows which bit ends up as the extra bit. Further patterns cover a frame that arrives while the previous result is still unread, a low pulse too short to be a start bit, and a one-sample glitch inside a data bit. The first shows the discard rule, the second the start check and the third the majority vote. A mode 0 transfer with the bench answering the shift clock shows the bit order and that the transfer does not restart until receive-done is cleared.

// File: rtl/mpc_rx_pkg.sv
package mpc_rx_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_8BIT  = 2'b01,
    MODE_9FIX  = 2'b10,
    MODE_9VAR  = 2'b11
  } rx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SER  = 2'b01,
    ST_SHF  = 2'b10
  } rx_state_e;

endpackage

// File: rtl/mpc_rx_sync.sv
module mpc_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_i,
  output logic line_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  // chain_d[0] takes the raw line, each later stage the previous one
  always_comb chain_d[0] = rxd_i;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_comb chain_d[g] = chain_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign line_o = chain_q[STAGES-1];
  assign fall_o = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/mpc_rx_vote.sv
module mpc_rx_vote #(
  parameter int OVS   = 16,
  parameter int CNT_W = $clog2(OVS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             line_i,
  output logic             decide_o,
  output logic             maj_o
);

  localparam logic [CNT_W-1:0] MID   = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] MID_A = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] MID_C = CNT_W'(OVS / 2 + 1);

  logic s0_q, s1_q, s0_d, s1_d;
  logic cap0, cap1;

  assign cap0 = tick_i && (cnt_i == MID_A);
  assign cap1 = tick_i && (cnt_i == MID);

  always_comb begin
    s0_d = s0_q;
    s1_d = s1_q;
    if (cap0) s0_d = line_i;
    if (cap1) s1_d = line_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b1;
      s1_q <= 1'b1;
    end else begin
      s0_q <= s0_d;
      s1_q <= s1_d;
    end
  end

  assign decide_o = tick_i && (cnt_i == MID_C);
  assign maj_o    = (s0_q & s1_q) | (s0_q & line_i) | (s1_q & line_i);

endmodule

// File: rtl/mpc_rx_fsm.sv
module mpc_rx_fsm
  import mpc_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int CNT_W  = $clog2(OVS),
  parameter int IDX_W  = $clog2(DATA_W + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en_i,
  input  logic [1:0]        mode_i,
  input  logic              ri_i,
  input  logic              line_i,
  input  logic              fall_i,
  input  logic              ovs_tick_i,
  input  logic              sh_tick_i,
  input  logic              decide_i,
  input  logic              maj_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ninth_o,
  output logic              stop_o,
  output logic              sclk_o
);

  localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_DLAST = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] IDX_STOP8 = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] IDX_STOP9 = IDX_W'(DATA_W + 2);
  localparam logic [IDX_W-1:0] IDX_SLAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shr_q, shr_d;
  logic              ninth_q, ninth_d;
  logic              sclk_q, sclk_d;
  logic              nine_bit;
  logic [IDX_W-1:0]  stop_idx;
  rx_mode_e          mode;

  assign mode     = rx_mode_e'(mode_i);
  assign nine_bit = mode_i[1];
  assign stop_idx = nine_bit ? IDX_STOP9 : IDX_STOP8;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shr_d   = shr_q;
    ninth_d = ninth_q;
    sclk_d  = sclk_q;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        sclk_d = 1'b1;
        if (rx_en_i) begin
          if (mode == MODE_SHIFT) begin
            if (!ri_i) begin
              state_d = ST_SHF;
              idx_d   = '0;
            end
          end else if (fall_i) begin
            state_d = ST_SER;
            cnt_d   = '0;
            idx_d   = '0;
          end
        end
      end
      ST_SER: begin
        if (!rx_en_i) begin
          state_d = ST_IDLE;
        end else if (ovs_tick_i) begin
          if (cnt_q == CNT_TOP) begin
            cnt_d = '0;
            idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
          if (decide_i) begin
            if (idx_q == '0) begin
              if (maj_i) state_d = ST_IDLE;
            end else if (idx_q <= IDX_DLAST) begin
              shr_d = {maj_i, shr_q[DATA_W-1:1]};
            end else if (idx_q == stop_idx) begin
              done_o  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              ninth_d = maj_i;
            end
          end
        end
      end
      ST_SHF: begin
        if (!rx_en_i) begin
          state_d = ST_IDLE;
          sclk_d  = 1'b1;
        end else if (sh_tick_i) begin
          if (sclk_q) begin
            sclk_d = 1'b0;
          end else begin
            sclk_d = 1'b1;
            shr_d  = {line_i, shr_q[DATA_W-1:1]};
            if (idx_q == IDX_SLAST) begin
              done_o  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shr_q   <= '0;
      ninth_q <= 1'b0;
      sclk_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shr_q   <= shr_d;
      ninth_q <= ninth_d;
      sclk_q  <= sclk_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign data_o  = shr_d;
  assign ninth_o = ninth_q;
  assign stop_o  = maj_i;
  assign sclk_o  = sclk_q;

endmodule

// File: rtl/mpc_rx_result.sv
module mpc_rx_result
  import mpc_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              addr_filt_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ninth_i,
  input  logic              stop_i,
  input  logic              clr_ri_i,
  input  logic              clr_fe_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              rb8_o,
  output logic              ri_o,
  output logic              fe_o
);

  logic [DATA_W-1:0] buf_q, buf_d;
  logic              rb8_q, rb8_d, ri_q, ri_d, fe_q, fe_d;
  logic              is_shift, is_8bit, accept, load, fe_set;
  rx_mode_e          mode;

  assign mode     = rx_mode_e'(mode_i);
  assign is_shift = (mode == MODE_SHIFT);
  assign is_8bit  = (mode == MODE_8BIT);
  assign accept   = is_shift | ~addr_filt_i | (is_8bit ? stop_i : ninth_i);
  assign load     = done_i & ~ri_q & accept;
  assign fe_set   = done_i & ~is_shift & ~stop_i;

  always_comb begin
    buf_d = buf_q;
    rb8_d = rb8_q;
    ri_d  = ri_q;
    fe_d  = fe_q;
    if (clr_ri_i) ri_d = 1'b0;
    if (clr_fe_i) fe_d = 1'b0;
    if (fe_set)   fe_d = 1'b1;
    if (load) begin
      buf_d = data_i;
      ri_d  = 1'b1;
      if (!is_shift) rb8_d = is_8bit ? stop_i : ninth_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      rb8_q <= 1'b0;
      ri_q  <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      buf_q <= buf_d;
      rb8_q <= rb8_d;
      ri_q  <= ri_d;
      fe_q  <= fe_d;
    end
  end

  assign buf_o = buf_q;
  assign rb8_o = rb8_q;
  assign ri_o  = ri_q;
  assign fe_o  = fe_q;

endmodule

// File: rtl/mpc_serial_rx.sv
module mpc_serial_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  input  logic              addr_filt_i,
  input  logic [1:0]        mode_i,
  input  logic              fe_view_i,
  input  logic              ovs_tick_i,
  input  logic              sh_tick_i,
  input  logic              clr_ri_i,
  input  logic              clr_fe_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rb8_o,
  output logic              ri_o,
  output logic              fe_o,
  output logic              ctrl7_o,
  output logic              sclk_o
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 3);

  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic              line, fall, decide, maj, done, ninth, stop;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] frame_data;
  logic              ri, fe;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  mpc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rxd_i  (rxd_i),
    .line_o (line),
    .fall_o (fall)
  );

  mpc_rx_vote #(.OVS(OVS), .CNT_W(CNT_W)) u_vote (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_i   (ovs_tick_i),
    .cnt_i    (cnt),
    .line_i   (line),
    .decide_o (decide),
    .maj_o    (maj)
  );

  mpc_rx_fsm #(.DATA_W(DATA_W), .OVS(OVS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rx_en_i    (rx_en_i),
    .mode_i     (mode_i),
    .ri_i       (ri),
    .line_i     (line),
    .fall_i     (fall),
    .ovs_tick_i (ovs_tick_i),
    .sh_tick_i  (sh_tick_i),
    .decide_i   (decide),
    .maj_i      (maj),
    .cnt_o      (cnt),
    .done_o     (done),
    .data_o     (frame_data),
    .ninth_o    (ninth),
    .stop_o     (stop),
    .sclk_o     (sclk_o)
  );

  mpc_rx_result #(.DATA_W(DATA_W)) u_result (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .mode_i      (mode_i),
    .addr_filt_i (addr_filt_i),
    .done_i      (done),
    .data_i      (frame_data),
    .ninth_i     (ninth),
    .stop_i      (stop),
    .clr_ri_i    (clr_ri_i),
    .clr_fe_i    (clr_fe_i),
    .buf_o       (rx_data_o),
    .rb8_o       (rb8_o),
    .ri_o        (ri),
    .fe_o        (fe)
  );

  assign ri_o    = ri;
  assign fe_o    = fe;
  assign ctrl7_o = fe_view_i ? fe : mode_i[1];

endmodule

// File: rtl/mpc_serial_rx_sva.sv
module mpc_serial_rx_sva #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en_i,
  input logic [1:0]        mode_i,
  input logic              clr_ri_i,
  input logic              clr_fe_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              ri_o,
  input logic              fe_o,
  input logic              sclk_o
);

  // R11: receive-done holds until cleared
  a_r11_ri_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ri_o && !clr_ri_i |=> ri_o);

  // R11: buffer cannot change while receive-done is set
  a_r11_buf_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ri_o |=> $stable(rx_data_o));

  // R6: framing error is sticky
  a_r6_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fe_o && !clr_fe_i |=> fe_o);

  // R6: framing error never comes from a mode 0 transfer
  a_r6_fe_not_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_o) |-> $past(mode_i) != 2'b00);

  // R8: no reception while disabled
  a_r8_no_ri_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i && !ri_o |=> !ri_o);

  // R8: shift clock idles high while disabled
  a_r8_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> sclk_o);

endmodule

bind mpc_serial_rx mpc_serial_rx_sva #(.DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en_i   (rx_en_i),
  .mode_i    (mode_i),
  .clr_ri_i  (clr_ri_i),
  .clr_fe_i  (clr_fe_i),
  .rx_data_o (rx_data_o),
  .ri_o      (ri_o),
  .fe_o      (fe_o),
  .sclk_o    (sclk_o)
);

// File: tb/mpc_serial_rx_bench.sv
module mpc_serial_rx_bench;

  localparam int DW       = 8;
  localparam int OVS      = 16;
  localparam int TICK_DIV = 2;
  localparam int BIT_CYC  = OVS * TICK_DIV;
  localparam int SH_DIV   = 8;

  logic          clk, rst_n, rxd, rx_en, filt, fe_view, ovs_tick, sh_tick;
  logic          clr_ri, clr_fe;
  logic [1:0]    mode;
  logic [DW-1:0] rx_data;
  logic          rb8, ri, fe, ctrl7, sclk;

  int checks = 0;
  int errors = 0;
  logic [DW:0] exp_q[$];
  string       tag_q[$];

  mpc_serial_rx #(.DATA_W(DW), .OVS(OVS)) u_mpc_serial_rx (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .rx_en_i(rx_en), .addr_filt_i(filt),
    .mode_i(mode), .fe_view_i(fe_view), .ovs_tick_i(ovs_tick), .sh_tick_i(sh_tick),
    .clr_ri_i(clr_ri), .clr_fe_i(clr_fe), .rx_data_o(rx_data), .rb8_o(rb8),
    .ri_o(ri), .fe_o(fe), .ctrl7_o(ctrl7), .sclk_o(sclk)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    ovs_tick = 1'b0;
    sh_tick  = 1'b0;
    for (int tc = 0; ; tc++) begin
      @(negedge clk);
      ovs_tick = (tc % TICK_DIV) == 0;
      sh_tick  = (tc % SH_DIV) == 0;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_frame(input logic [DW-1:0] d, input logic b8, input string req);
    exp_q.push_back({b8, d});
    tag_q.push_back(req);
  endtask

  // monitor: every rise of receive-done must match the next expected result
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (ri === 1'b1 && !prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected receive-done", 1, 0);
        end else begin
          logic [DW:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({rb8, rx_data} == e, t, "buffer/extra bit", int'({rb8, rx_data}), int'(e));
        end
      end
      prev = (ri === 1'b1);
    end
  end

  task automatic drive_bit(input logic v, input bit glitch);
    for (int c = 0; c < BIT_CYC; c++) begin
      @(negedge clk);
      rxd = (glitch && (c == 18 || c == 19)) ? ~v : v;
    end
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input logic nb, input logic sb,
                            input int gl_bit);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < DW; i++) drive_bit(d[i], gl_bit == i);
    if (mode[1]) drive_bit(nb, 1'b0);
    drive_bit(sb, 1'b0);
    drive_bit(1'b1, 1'b0);
  endtask

  task automatic pulse_clr_ri();
    @(negedge clk) clr_ri = 1'b1;
    @(negedge clk) clr_ri = 1'b0;
  endtask

  task automatic pulse_clr_fe();
    @(negedge clk) clr_fe = 1'b1;
    @(negedge clk) clr_fe = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rx_en = 1'b0; filt = 1'b0; fe_view = 1'b0;
    mode = 2'b00; clr_ri = 1'b0; clr_fe = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check(ri == 1'b0, "R1", "ri", ri, 0);
    check(fe == 1'b0, "R1", "fe", fe, 0);
    check(rx_data == '0 && rb8 == 1'b0, "R1", "buffer", int'({rb8, rx_data}), 0);
    check(sclk == 1'b1, "R1", "sclk idle", sclk, 1);

    // R8 disabled: frame ignored
    mode = 2'b01;
    send_frame(8'h5A, 1'b0, 1'b1, -1);
    check(ri == 1'b0, "R8", "ri while disabled", ri, 0);
    check(rx_data == '0, "R8", "buffer while disabled", rx_data, 0);

    // R2 mode 1 frames
    rx_en = 1'b1;
    expect_frame(8'hA5, 1'b1, "R2");
    send_frame(8'hA5, 1'b0, 1'b1, -1);
    check(ri == 1'b1, "R2", "ri after frame", ri, 1);
    pulse_clr_ri();
    check(ri == 1'b0, "R13", "ri after clear", ri, 0);
    expect_frame(8'h01, 1'b1, "R2");
    send_frame(8'h01, 1'b0, 1'b1, -1);
    pulse_clr_ri();

    // R11 overrun discarded
    expect_frame(8'h3C, 1'b1, "R11");
    send_frame(8'h3C, 1'b0, 1'b1, -1);
    send_frame(8'hFF, 1'b0, 1'b1, -1);
    check(rx_data == 8'h3C, "R11", "buffer kept", rx_data, 8'h3C);
    check(ri == 1'b1, "R11", "ri kept", ri, 1);
    pulse_clr_ri();

    // R3 nine-bit modes
    mode = 2'b10;
    expect_frame(8'h96, 1'b1, "R3");
    send_frame(8'h96, 1'b1, 1'b1, -1);
    pulse_clr_ri();
    mode = 2'b11;
    expect_frame(8'h42, 1'b0, "R3");
    send_frame(8'h42, 1'b0, 1'b1, -1);
    pulse_clr_ri();
    check(fe == 1'b0, "R6", "fe after valid frames", fe, 0);

    // R4 address filter on ninth bit
    filt = 1'b1;
    send_frame(8'h7E, 1'b0, 1'b1, -1);
    check(ri == 1'b0, "R4", "ri for ninth=0", ri, 0);
    check(rx_data == 8'h42 && rb8 == 1'b0, "R4", "buffer kept", int'({rb8, rx_data}), 9'h042);
    expect_frame(8'h81, 1'b1, "R4");
    send_frame(8'h81, 1'b1, 1'b1, -1);
    pulse_clr_ri();

    // R5 filter on stop bit in mode 1, R6 sticky error
    mode = 2'b01;
    send_frame(8'h55, 1'b0, 1'b0, -1);
    check(ri == 1'b0, "R5", "ri for bad stop", ri, 0);
    check(rx_data == 8'h81, "R5", "buffer kept", rx_data, 8'h81);
    check(fe == 1'b1, "R6", "fe set", fe, 1);
    expect_frame(8'h66, 1'b1, "R5");
    send_frame(8'h66, 1'b0, 1'b1, -1);
    check(fe == 1'b1, "R6", "fe kept after valid frame", fe, 1);
    pulse_clr_ri();

    // R7 shared bit view
    @(negedge clk) fe_view = 1'b1;
    #1 check(ctrl7 == 1'b1, "R7", "view fe", ctrl7, 1);
    @(negedge clk) fe_view = 1'b0;
    #1 check(ctrl7 == 1'b0, "R7", "view mode bit (mode 1)", ctrl7, 0);
    @(negedge clk) mode = 2'b10;
    #1 check(ctrl7 == 1'b1, "R7", "view mode bit (mode 2)", ctrl7, 1);
    pulse_clr_fe();
    check(fe == 1'b0, "R6", "fe cleared", fe, 0);
    fe_view = 1'b1;
    #1 check(ctrl7 == 1'b0, "R7", "view cleared fe", ctrl7, 0);
    fe_view = 1'b0;

    // R3 + R6: stop ignored for extra bit in mode 3 but still flags error
    mode = 2'b11; filt = 1'b0;
    expect_frame(8'h24, 1'b1, "R3");
    send_frame(8'h24, 1'b1, 1'b0, -1);
    check(fe == 1'b1, "R6", "fe in mode 3", fe, 1);
    pulse_clr_ri();
    pulse_clr_fe();

    // R2: unfiltered mode 1 bad stop still loads, stop stored as 0
    mode = 2'b01;
    expect_frame(8'h99, 1'b0, "R2");
    send_frame(8'h99, 1'b0, 1'b0, -1);
    pulse_clr_ri();
    pulse_clr_fe();

    // R9 short low pulse rejected
    for (int c = 0; c < 6; c++) begin @(negedge clk); rxd = 1'b0; end
    @(negedge clk) rxd = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
    check(ri == 1'b0, "R9", "ri after short pulse", ri, 0);
    expect_frame(8'h5C, 1'b1, "R9");
    send_frame(8'h5C, 1'b0, 1'b1, -1);
    pulse_clr_ri();

    // R10 single-sample glitches
    expect_frame(8'hB7, 1'b1, "R10");
    send_frame(8'hB7, 1'b0, 1'b1, 3);
    pulse_clr_ri();
    expect_frame(8'h08, 1'b1, "R10");
    send_frame(8'h08, 1'b0, 1'b1, 3);
    pulse_clr_ri();

    // R12 mode 0 transfer
    @(negedge clk) begin rx_en = 1'b0; mode = 2'b00; end
    repeat (4) @(negedge clk);
    expect_frame(8'hC3, 1'b1, "R12");
    @(negedge clk) rx_en = 1'b1;
    for (int i = 0; i < DW; i++) begin
      @(negedge sclk);
      @(negedge clk) rxd = 8'hC3 >> i;
    end
    repeat (20) @(negedge clk);
    check(ri == 1'b1, "R12", "ri after shift", ri, 1);
    begin
      bit stayed;
      stayed = 1'b1;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (sclk !== 1'b1) stayed = 1'b0;
      end
      check(stayed, "R12", "sclk high while ri set", int'(stayed), 1);
    end
    @(negedge clk) rx_en = 1'b0;
    pulse_clr_ri();
    rxd = 1'b1;
    repeat (4) @(negedge clk);

    check(exp_q.size() == 0, "R2", "missing receive-done events", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule